// File: doc/BRIEF.md
# Parallel Port Event Interrupt Controller

This block sits on the peripheral side of an IEEE 1284 style parallel port. It watches the host strobe, the host select-in line and the busy line. It also takes single-cycle status strobes from the transfer engine: a run-length byte was taken, a channel address was taken, the decompressor produced a byte, and the transmit register became free. From these it posts four latched events. Which events it posts depends on the port mode and on the direction of the data bus.

Each event has its own pending bit and enable bit. Software clears pending bits by writing ones. One registered interrupt line goes high when any enabled event is pending. The three pin inputs are asynchronous to the block clock. Each passes through a two-flop synchronizer before its edges are detected, so that each pin edge is counted once.

Top module: `ppi_event_irq`

## Requirements
- R1: After reset, `pend_o`, `en_o` and `irq_o` are all zero.
- R2: A falling edge on `strobe_ni` sets pending bit 0 (data) when `bus_dir_i` is 0, in any mode. The bit is set at the third rising clock edge after the pin changes. A pin held low sets the bit only once, and no edge sets it while `bus_dir_i` is 1.
- R3: A `decomp_byte_i` pulse sets pending bit 0 only in ECP-with-RLE mode (`mode_i` = 2'b10).
- R4: Pending bit 1 (command) is set by either `cmd_rl_i` or `cmd_ch_i` in ECP-without-RLE mode (`mode_i` = 2'b01). In ECP-with-RLE mode only `cmd_ch_i` sets it. In compatibility mode (2'b00, and the reserved code 2'b11) neither sets it.
- R5: A synchronized falling edge on `slctin_ni` sets pending bit 2 (invalid transition) when all of the following hold: the port is in an ECP mode, `bus_dir_i` is 0, and `strobe_ni` is low or `busy_i` is high. Otherwise the edge does not set it.
- R6: A `tx_free_i` pulse sets pending bit 3 (transmit empty) only in an ECP mode with `bus_dir_i` = 1.
- R7: A cycle with `en_wr_i` high loads `en_wdata_i` into the enable register. Without a write, the enable register holds its value.
- R8: Each 1 in `clr_i` clears that pending bit one cycle later. A set event and a clear on the same bit in the same cycle leave the bit set.
- R9: `irq_o` equals the OR over all bits of (pending AND enable) as it was one clock earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_ni | input | 1 | Host data strobe pin, active low, asynchronous |
| slctin_ni | input | 1 | Host select-in pin, active low, asynchronous |
| busy_i | input | 1 | Busy line, asynchronous |
| bus_dir_i | input | 1 | Data bus direction: 0 = forward (host to peripheral), 1 = reverse |
| mode_i | input | 2 | 00 compatibility, 01 ECP without RLE, 10 ECP with RLE, 11 reserved (treated as compatibility) |
| cmd_rl_i | input | 1 | Run-length byte received, one-cycle pulse |
| cmd_ch_i | input | 1 | Channel address received, one-cycle pulse |
| decomp_byte_i | input | 1 | Decompressor produced a byte, one-cycle pulse |
| tx_free_i | input | 1 | Transmit register writable, one-cycle pulse |
| en_wr_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 4 | Enable register write data |
| clr_i | input | 4 | Write-1-to-clear strobes for the pending bits |
| en_o | output | 4 | Enable register |
| pend_o | output | 4 | Pending register: bit 0 data, 1 command, 2 invalid transition, 3 transmit empty |
| irq_o | output | 1 | Interrupt request, registered |

## Verification
The assertions check several properties on every cycle. The interrupt always follows the previous cycle's pending and enable bits one cycle later. The enable register changes only on a write. A pending bit falls only when it was cleared. The command, invalid-transition and transmit-empty bits rise only in a mode and direction that allow them. The bench scenarios cover what a single-cycle property cannot show: the exact three-cycle latency through the synchronizers, the single count of a held strobe, which command source counts in each mode, the qualification of select-in by strobe and busy, and a set beating a clear in the same cycle.

// File: rtl/ppi_evt_pkg.sv
package ppi_evt_pkg;
  localparam int unsigned N_EVT = 4;

  typedef enum logic [1:0] {
    MODE_COMPAT  = 2'b00,
    MODE_ECP     = 2'b01,
    MODE_ECP_RLE = 2'b10,
    MODE_RSVD    = 2'b11
  } port_mode_e;

  typedef enum int unsigned {
    EVT_DATA = 0,
    EVT_CMD  = 1,
    EVT_INV  = 2,
    EVT_TXE  = 3
  } evt_idx_e;

  function automatic logic is_ecp(input logic [1:0] m);
    return (m == MODE_ECP) || (m == MODE_ECP_RLE);
  endfunction
endpackage

// File: rtl/ppi_sync.sv
module ppi_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= RST_VAL;
        else         sr_q <= d_i;
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/ppi_fall_det.sv
module ppi_fall_det #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= d_i;

  assign fall_o = prev_q & ~d_i;
endmodule

// File: rtl/ppi_evt_qual.sv
module ppi_evt_qual
  import ppi_evt_pkg::*;
(
  input  logic [1:0]       mode_i,
  input  logic             bus_dir_i,
  input  logic             strobe_fall_i,
  input  logic             slctin_fall_i,
  input  logic             strobe_lvl_i,
  input  logic             busy_lvl_i,
  input  logic             decomp_byte_i,
  input  logic             cmd_rl_i,
  input  logic             cmd_ch_i,
  input  logic             tx_free_i,
  output logic [N_EVT-1:0] set_o
);
  logic ecp, rle, fwd;

  always_comb begin
    ecp = is_ecp(mode_i);
    rle = (mode_i == MODE_ECP_RLE);
    fwd = ~bus_dir_i;

    set_o = '0;
    set_o[EVT_DATA] = (strobe_fall_i & fwd) | (decomp_byte_i & rle);
    // with RLE on, run-length bytes are consumed by the decompressor
    set_o[EVT_CMD]  = ecp & (cmd_ch_i | (cmd_rl_i & ~rle));
    set_o[EVT_INV]  = ecp & fwd & slctin_fall_i & (~strobe_lvl_i | busy_lvl_i);
    set_o[EVT_TXE]  = ecp & bus_dir_i & tx_free_i;
  end
endmodule

// File: rtl/ppi_pend_reg.sv
module ppi_pend_reg #(
  parameter int unsigned NB = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NB-1:0] set_i,
  input  logic [NB-1:0] clr_i,
  input  logic          en_wr_i,
  input  logic [NB-1:0] en_wdata_i,
  output logic [NB-1:0] pend_o,
  output logic [NB-1:0] en_o,
  output logic          irq_o
);
  logic [NB-1:0] pend_q, en_q;
  logic          irq_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~clr_i) | set_i;  // set wins over clear
      if (en_wr_i) en_q <= en_wdata_i;
      irq_q  <= |(pend_q & en_q);
    end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/ppi_event_irq.sv
module ppi_event_irq
  import ppi_evt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_ni,
  input  logic             slctin_ni,
  input  logic             busy_i,
  input  logic             bus_dir_i,
  input  logic [1:0]       mode_i,
  input  logic             cmd_rl_i,
  input  logic             cmd_ch_i,
  input  logic             decomp_byte_i,
  input  logic             tx_free_i,
  input  logic             en_wr_i,
  input  logic [N_EVT-1:0] en_wdata_i,
  input  logic [N_EVT-1:0] clr_i,
  output logic [N_EVT-1:0] en_o,
  output logic [N_EVT-1:0] pend_o,
  output logic             irq_o
);
  localparam int unsigned N_PIN  = 3;
  localparam int unsigned N_EDGE = 2;
  // pin order: 0 strobe, 1 select-in, 2 busy; idle levels below
  localparam logic [N_PIN-1:0] PIN_IDLE = 3'b011;

  logic [N_PIN-1:0]  pin_raw, pin_s;
  logic [N_EDGE-1:0] pin_fall;
  logic [N_EVT-1:0]  evt_set;

  assign pin_raw = {busy_i, slctin_ni, strobe_ni};

  for (genvar i = 0; i < N_PIN; i++) begin : g_sync
    ppi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE[i])) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pin_raw[i]),
      .q_o   (pin_s[i])
    );
  end

  for (genvar i = 0; i < N_EDGE; i++) begin : g_fall
    ppi_fall_det #(.RST_VAL(PIN_IDLE[i])) u_fall (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pin_s[i]),
      .fall_o(pin_fall[i])
    );
  end

  ppi_evt_qual u_qual (
    .mode_i        (mode_i),
    .bus_dir_i     (bus_dir_i),
    .strobe_fall_i (pin_fall[0]),
    .slctin_fall_i (pin_fall[1]),
    .strobe_lvl_i  (pin_s[0]),
    .busy_lvl_i    (pin_s[2]),
    .decomp_byte_i (decomp_byte_i),
    .cmd_rl_i      (cmd_rl_i),
    .cmd_ch_i      (cmd_ch_i),
    .tx_free_i     (tx_free_i),
    .set_o         (evt_set)
  );

  ppi_pend_reg #(.NB(N_EVT)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (evt_set),
    .clr_i     (clr_i),
    .en_wr_i   (en_wr_i),
    .en_wdata_i(en_wdata_i),
    .pend_o    (pend_o),
    .en_o      (en_o),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/ppi_event_irq_chk.sv
module ppi_event_irq_chk
  import ppi_evt_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_dir_i,
  input logic [1:0]       mode_i,
  input logic             en_wr_i,
  input logic [N_EVT-1:0] en_wdata_i,
  input logic [N_EVT-1:0] clr_i,
  input logic [N_EVT-1:0] en_o,
  input logic [N_EVT-1:0] pend_o,
  input logic             irq_o
);
  // R9
  irq_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(|(pend_o & en_o)));

  // R7
  en_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_wr_i |=> en_o == $past(en_wdata_i));

  // R7
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_wr_i |=> $stable(en_o));

  // R8
  for (genvar k = 0; k < N_EVT; k++) begin : g_fall
    pend_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pend_o[k]) |-> $past(clr_i[k]));
  end

  // R4
  cmd_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_o[EVT_CMD]) |-> $past(is_ecp(mode_i)));

  // R5
  inv_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_o[EVT_INV]) |-> $past(is_ecp(mode_i) && !bus_dir_i));

  // R6
  txe_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_o[EVT_TXE]) |-> $past(is_ecp(mode_i) && bus_dir_i));
endmodule

bind ppi_event_irq ppi_event_irq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bus_dir_i (bus_dir_i),
  .mode_i    (mode_i),
  .en_wr_i   (en_wr_i),
  .en_wdata_i(en_wdata_i),
  .clr_i     (clr_i),
  .en_o      (en_o),
  .pend_o    (pend_o),
  .irq_o     (irq_o)
);

// File: tb/sim_ppi_event_irq.sv
module sim_ppi_event_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe_n = 1'b1, slctin_n = 1'b1, busy = 1'b0, bus_dir = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       cmd_rl = 0, cmd_ch = 0, decomp = 0, tx_free = 0, en_wr = 0;
  logic [3:0] en_wdata = '0, clr = '0;
  logic [3:0] en, pend;
  logic       irq;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #10 clk = ~clk;  // 50 MHz

  ppi_event_irq u0 (
    .clk_i(clk), .rst_ni(rst_n), .strobe_ni(strobe_n), .slctin_ni(slctin_n),
    .busy_i(busy), .bus_dir_i(bus_dir), .mode_i(mode), .cmd_rl_i(cmd_rl),
    .cmd_ch_i(cmd_ch), .decomp_byte_i(decomp), .tx_free_i(tx_free),
    .en_wr_i(en_wr), .en_wdata_i(en_wdata), .clr_i(clr),
    .en_o(en), .pend_o(pend), .irq_o(irq)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic rl, input logic ch, input logic dc, input logic tx);
    cmd_rl = rl; cmd_ch = ch; decomp = dc; tx_free = tx;
    step(1);
    cmd_rl = 0; cmd_ch = 0; decomp = 0; tx_free = 0;
  endtask

  task automatic clear_all();
    clr = 4'hF; step(1); clr = '0;
  endtask

  task automatic t_reset();
    chk("R1 pend", pend, 4'h0);
    chk("R1 en", en, 4'h0);
    chk("R1 irq", irq, 1'b0);
  endtask

  task automatic t_data_strobe();
    mode = 2'b00; bus_dir = 0;
    strobe_n = 0;
    step(2); chk("R2 latency not yet", pend, 4'h0);
    step(1); chk("R2 third edge", pend, 4'h1);
    clr = 4'h1; step(1); clr = '0;
    chk("R8 cleared", pend, 4'h0);
    step(3); chk("R2 held low counted once", pend, 4'h0);
    strobe_n = 1; step(3);
    bus_dir = 1; strobe_n = 0; step(4);
    chk("R2 reverse ignored", pend, 4'h0);
    strobe_n = 1; bus_dir = 0; step(3);
    mode = 2'b01; strobe_n = 0; step(3);
    chk("R2 in ECP mode", pend, 4'h1);
    strobe_n = 1; step(3); clear_all();
  endtask

  task automatic t_decomp();
    mode = 2'b10; pulse(0, 0, 1, 0);
    chk("R3 RLE decomp", pend, 4'h1);
    clear_all();
    mode = 2'b01; pulse(0, 0, 1, 0);
    chk("R3 no-RLE decomp ignored", pend, 4'h0);
    mode = 2'b00; pulse(0, 0, 1, 0);
    chk("R3 compat decomp ignored", pend, 4'h0);
  endtask

  task automatic t_cmd();
    mode = 2'b01; pulse(1, 0, 0, 0);
    chk("R4 no-RLE run-length", pend, 4'h2); clear_all();
    pulse(0, 1, 0, 0);
    chk("R4 no-RLE channel", pend, 4'h2); clear_all();
    mode = 2'b10; pulse(1, 0, 0, 0);
    chk("R4 RLE run-length ignored", pend, 4'h0);
    pulse(0, 1, 0, 0);
    chk("R4 RLE channel", pend, 4'h2); clear_all();
    mode = 2'b00; pulse(1, 1, 0, 0);
    chk("R4 compat ignored", pend, 4'h0);
    mode = 2'b11; pulse(1, 1, 0, 0);
    chk("R4 reserved ignored", pend, 4'h0);
  endtask

  task automatic t_invalid();
    mode = 2'b01; bus_dir = 0;
    strobe_n = 0; step(4); clear_all();
    slctin_n = 0; step(4);
    chk("R5 select-in fall strobe low", pend, 4'h4);
    slctin_n = 1; strobe_n = 1; step(4); clear_all();
    busy = 1; step(3);
    slctin_n = 0; step(4);
    chk("R5 select-in fall busy high", pend, 4'h4);
    slctin_n = 1; busy = 0; step(4); clear_all();
    slctin_n = 0; step(4);
    chk("R5 idle handshake ignored", pend, 4'h0);
    slctin_n = 1; step(4);
    mode = 2'b00; busy = 1; step(3);
    slctin_n = 0; step(4);
    chk("R5 compat ignored", pend, 4'h0);
    slctin_n = 1; busy = 0; step(4);
    mode = 2'b10; bus_dir = 1; busy = 1; step(3);
    slctin_n = 0; step(4);
    chk("R5 reverse ignored", pend, 4'h0);
    slctin_n = 1; busy = 0; bus_dir = 0; step(4); clear_all();
  endtask

  task automatic t_txe();
    mode = 2'b10; bus_dir = 1; pulse(0, 0, 0, 1);
    chk("R6 ECP reverse", pend, 4'h8); clear_all();
    bus_dir = 0; pulse(0, 0, 0, 1);
    chk("R6 forward ignored", pend, 4'h0);
    mode = 2'b00; bus_dir = 1; pulse(0, 0, 0, 1);
    chk("R6 compat ignored", pend, 4'h0);
    bus_dir = 0;
  endtask

  task automatic t_enable_irq();
    en_wr = 1; en_wdata = 4'b0010; step(1); en_wr = 0; en_wdata = 4'hF;
    chk("R7 loaded", en, 4'b0010);
    step(2); chk("R7 held", en, 4'b0010);
    mode = 2'b10; pulse(0, 0, 1, 0);
    step(1); chk("R9 masked pending no irq", irq, 1'b0);
    pulse(0, 1, 0, 0);
    chk("R9 pending seen", pend, 4'h3);
    chk("R9 irq one cycle late", irq, 1'b0);
    step(1); chk("R9 irq raised", irq, 1'b1);
    clr = 4'h2; step(1); clr = '0;
    chk("R9 irq still from old state", irq, 1'b1);
    step(1); chk("R9 irq dropped", irq, 1'b0);
    clear_all();
  endtask

  task automatic t_set_wins();
    mode = 2'b01; pulse(0, 1, 0, 0);
    chk("R8 pre-set", pend, 4'h2);
    clr = 4'h2; cmd_ch = 1; step(1); clr = '0; cmd_ch = 0;
    chk("R8 set wins clear", pend, 4'h2);
    pulse(0, 0, 0, 0); chk("R8 event-free hold", pend, 4'h2);
    clr = 4'h2; step(1); clr = '0;
    chk("R8 plain clear", pend, 4'h0);
  endtask

  initial begin
    step(2); rst_n = 1; step(1);
    t_reset();
    t_data_strobe();
    t_decomp();
    t_cmd();
    t_invalid();
    t_txe();
    t_enable_irq();
    t_set_wins();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule